// File: doc/BRIEF.md
# Serial Port Configuration Register File

This block is the bus-side register file of a serial port. It holds the frame-format register, a control register with the transmitter and receiver enables, and a 12-bit baud divisor. A simple single-cycle write port (address, write strobe, byte) updates it. Reads are combinational and show the register contents before any write in that cycle. The transmitter, receiver and baud generator read their configuration from the decoded outputs. Those outputs give the mode, the parity type, the stop-bit count, the character length in bits, the clock polarity and the active divisor.

The format register and the upper divisor byte have one shared address. Bit 7 of the written byte chooses the target. When bit 7 is set, bits 6:0 go into the format register. When bit 7 is clear, the low nibble is held as the staged upper part of the divisor. The lower divisor byte has its own address, which is not next to the shared one. Writing the lower byte commits the staged upper nibble and the new lower byte to the active divisor together, so the baud generator never sees a divisor that is half updated.

Top module: `uart_cfg_regs`

## Requirements
- R1: After reset, the shared address reads 0x86, the control address reads 0x00, the divisor-low address reads 0x00 and `divisor_o` is 0. Reset selects asynchronous mode, no parity, one stop bit, 8-bit characters, clock polarity 0, and both enables off.
- R2: A write to the shared address (7) with bit 7 set loads bits 6:0 into the format register. Bit 6 is mode, bits 5:4 are parity, bit 3 is the two-stop select, bits 2:1 are size, and bit 0 is clock polarity. The staged divisor nibble is left unchanged.
- R3: A write to the shared address with bit 7 clear stores bits 3:0 as the staged upper divisor nibble and leaves the format register unchanged.
- R4: A read of the shared address always returns bit 7 as 1 and bits 6:0 as the format register.
- R5: A write to the divisor-low address (2) sets `divisor_o` to {staged nibble, written byte} on the next cycle. That address reads back `divisor_o[7:0]`.
- R6: `divisor_o` changes only in the cycle after a write to the divisor-low address.
- R7: The control register at address 1 holds size bit 2 in bit 0, the transmitter enable in bit 1 and the receiver enable in bit 2. Bits 7:3 read as zero.
- R8: `char_bits_o` decodes {control bit 0, format size[1:0]} as follows: 000 gives 5, 001 gives 6, 010 gives 7, 011 gives 8 and 111 gives 9. The reserved codes 100, 101 and 110 give 8.
- R9: Format parity 00 and the reserved code 01 both disable parity. Parity 10 selects even and 11 selects odd (`parity_en_o`, `parity_odd_o`).
- R10: `sync_mode_o`, `stop2_o` and `clk_pol_o` follow format bits 6, 3 and 0.
- R11: Reads of unmapped addresses return 0, and writes to them change no register.
- R12: A read in the same cycle as a write to the same address returns the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data |
| tx_en_o | output | 1 | Transmitter enable |
| rx_en_o | output | 1 | Receiver enable |
| sync_mode_o | output | 1 | 1 selects synchronous mode |
| parity_en_o | output | 1 | Parity generation and check enabled |
| parity_odd_o | output | 1 | Odd parity when enabled |
| stop2_o | output | 1 | Two stop bits |
| char_bits_o | output | 4 | Character length in bits (5 to 9) |
| clk_pol_o | output | 1 | Synchronous clock polarity |
| divisor_o | output | DIV_W | Active baud divisor |

## Verification
Two things can fall in the same cycle: a read and a write to the same address, because the read is combinational and the write lands on the edge. The bench provokes this by driving writes to the shared, control and divisor-low addresses while it reads those same addresses. It judges the result by checking that the read data match the reference model's state from before the write, and that the decoded outputs in the next cycle match the state after it. A second case is the staged divisor nibble meeting a commit. A steering write with bit 7 clear, followed by format writes and then a low-byte write, must yield a divisor built from the nibble that was staged earlier.

// File: rtl/uart_cfg_pkg.sv
package uart_cfg_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef struct packed {
    logic       sync_mode;
    logic [1:0] parity;
    logic       stop2;
    logic [1:0] size;
    logic       clk_pol;
  } fmt_t;

  typedef struct packed {
    logic rx_en;
    logic tx_en;
    logic size2;
  } ctl_t;

  localparam int unsigned FMT_W = $bits(fmt_t);
  localparam int unsigned CTL_W = $bits(ctl_t);

  localparam fmt_t FMT_RST = '{sync_mode: 1'b0, parity: 2'b00, stop2: 1'b0,
                               size: 2'b11, clk_pol: 1'b0};
  localparam ctl_t CTL_RST = '{rx_en: 1'b0, tx_en: 1'b0, size2: 1'b0};

  function automatic logic [3:0] size_to_bits(input logic s2, input logic [1:0] s);
    case ({s2, s})
      3'b000:  return 4'd5;
      3'b001:  return 4'd6;
      3'b010:  return 4'd7;
      3'b111:  return 4'd9;
      default: return 4'd8;  // 011 and reserved codes
    endcase
  endfunction
endpackage

// File: rtl/uart_fmt_reg.sv
module uart_fmt_reg
  import uart_cfg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [FMT_W-1:0] wdata_i,
  output fmt_t             fmt_o
);
  fmt_t fmt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   fmt_q <= FMT_RST;
    else if (wr_i) fmt_q <= fmt_t'(wdata_i);
  end

  assign fmt_o = fmt_q;
endmodule

// File: rtl/uart_ctl_reg.sv
module uart_ctl_reg
  import uart_cfg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CTL_W-1:0] wdata_i,
  output ctl_t             ctl_o
);
  ctl_t ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctl_q <= CTL_RST;
    else if (wr_i) ctl_q <= ctl_t'(wdata_i);
  end

  assign ctl_o = ctl_q;
endmodule

// File: rtl/uart_div_reg.sv
module uart_div_reg
  import uart_cfg_pkg::*;
#(
  parameter int unsigned DIV_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hi_wr_i,
  input  logic              lo_wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [DIV_W-1:0]  div_o
);
  localparam int unsigned HI_W = DIV_W - BYTE_W;

  logic [HI_W-1:0]  hi_stage_q;
  logic [DIV_W-1:0] div_q;

  // upper part is staged; the active divisor only moves on a low-byte write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_stage_q <= '0;
      div_q      <= '0;
    end else begin
      if (hi_wr_i) hi_stage_q <= wdata_i[HI_W-1:0];
      if (lo_wr_i) div_q      <= {hi_stage_q, wdata_i};
    end
  end

  assign div_o = div_q;
endmodule

// File: rtl/uart_fmt_decode.sv
module uart_fmt_decode
  import uart_cfg_pkg::*;
(
  input  fmt_t       fmt_i,
  input  logic       size2_i,
  output logic       sync_mode_o,
  output logic       parity_en_o,
  output logic       parity_odd_o,
  output logic       stop2_o,
  output logic [3:0] char_bits_o,
  output logic       clk_pol_o
);
  always_comb begin
    sync_mode_o  = fmt_i.sync_mode;
    stop2_o      = fmt_i.stop2;
    clk_pol_o    = fmt_i.clk_pol;
    // 01 is reserved: treated as parity off
    parity_en_o  = fmt_i.parity[1];
    parity_odd_o = fmt_i.parity[1] & fmt_i.parity[0];
    char_bits_o  = size_to_bits(size2_i, fmt_i.size);
  end
endmodule

// File: rtl/uart_cfg_regs.sv
module uart_cfg_regs
  import uart_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned DIV_W       = 12,
  parameter int unsigned ADDR_CTL    = 1,
  parameter int unsigned ADDR_DIV_LO = 2,
  parameter int unsigned ADDR_SHARED = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              tx_en_o,
  output logic              rx_en_o,
  output logic              sync_mode_o,
  output logic              parity_en_o,
  output logic              parity_odd_o,
  output logic              stop2_o,
  output logic [3:0]        char_bits_o,
  output logic              clk_pol_o,
  output logic [DIV_W-1:0]  divisor_o
);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(ADDR_CTL);
  localparam logic [ADDR_W-1:0] A_LO  = ADDR_W'(ADDR_DIV_LO);
  localparam logic [ADDR_W-1:0] A_SH  = ADDR_W'(ADDR_SHARED);
  localparam int unsigned       SEL_B = BYTE_W - 1;

  logic sel_ctl, sel_lo, sel_sh;
  logic fmt_wr, hi_wr, ctl_wr, lo_wr;
  fmt_t fmt;
  ctl_t ctl;

  assign sel_ctl = (addr_i == A_CTL);
  assign sel_lo  = (addr_i == A_LO);
  assign sel_sh  = (addr_i == A_SH);

  // bit 7 of a shared-address write steers it
  assign fmt_wr = we_i & sel_sh &  wdata_i[SEL_B];
  assign hi_wr  = we_i & sel_sh & ~wdata_i[SEL_B];
  assign ctl_wr = we_i & sel_ctl;
  assign lo_wr  = we_i & sel_lo;

  uart_fmt_reg u_fmt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (fmt_wr),
    .wdata_i (wdata_i[FMT_W-1:0]),
    .fmt_o   (fmt)
  );

  uart_ctl_reg u_ctl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (ctl_wr),
    .wdata_i (wdata_i[CTL_W-1:0]),
    .ctl_o   (ctl)
  );

  uart_div_reg #(.DIV_W(DIV_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hi_wr_i (hi_wr),
    .lo_wr_i (lo_wr),
    .wdata_i (wdata_i),
    .div_o   (divisor_o)
  );

  uart_fmt_decode u_dec (
    .fmt_i        (fmt),
    .size2_i      (ctl.size2),
    .sync_mode_o  (sync_mode_o),
    .parity_en_o  (parity_en_o),
    .parity_odd_o (parity_odd_o),
    .stop2_o      (stop2_o),
    .char_bits_o  (char_bits_o),
    .clk_pol_o    (clk_pol_o)
  );

  assign tx_en_o = ctl.tx_en;
  assign rx_en_o = ctl.rx_en;

  always_comb begin
    rdata_o = '0;
    if (sel_sh)       rdata_o = {1'b1, fmt};
    else if (sel_ctl) rdata_o = {{(BYTE_W-CTL_W){1'b0}}, ctl};
    else if (sel_lo)  rdata_o = divisor_o[BYTE_W-1:0];
  end
endmodule

// File: rtl/uart_cfg_regs_chk.sv
module uart_cfg_regs_chk #(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned DIV_W       = 12,
  parameter int unsigned ADDR_CTL    = 1,
  parameter int unsigned ADDR_DIV_LO = 2,
  parameter int unsigned ADDR_SHARED = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [7:0]        wdata_i,
  input logic [7:0]        rdata_o,
  input logic              tx_en_o,
  input logic              parity_en_o,
  input logic              parity_odd_o,
  input logic              sync_mode_o,
  input logic              stop2_o,
  input logic [3:0]        char_bits_o,
  input logic              clk_pol_o,
  input logic [DIV_W-1:0]  divisor_o
);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(ADDR_CTL);
  localparam logic [ADDR_W-1:0] A_LO  = ADDR_W'(ADDR_DIV_LO);
  localparam logic [ADDR_W-1:0] A_SH  = ADDR_W'(ADDR_SHARED);

  AST_SHARED_MSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_SH) |-> rdata_o[7]);  // R4

  AST_FMT_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_SH && wdata_i[7]) |=>
      (stop2_o == $past(wdata_i[3]) && sync_mode_o == $past(wdata_i[6])));  // R2

  AST_HI_KEEPS_FMT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_SH && !wdata_i[7]) |=>
      $stable({sync_mode_o, parity_en_o, parity_odd_o, stop2_o, char_bits_o, clk_pol_o}));  // R3

  AST_DIV_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_LO) |=> (divisor_o[7:0] == $past(wdata_i)));  // R5

  AST_DIV_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == A_LO) |=> $stable(divisor_o));  // R6

  AST_CTL_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_CTL) |=> (tx_en_o == $past(wdata_i[1])));  // R7

  AST_CHAR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_bits_o >= 4'd5 && char_bits_o <= 4'd9));  // R8

  AST_ODD_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    parity_odd_o |-> parity_en_o);  // R9
endmodule

bind uart_cfg_regs uart_cfg_regs_chk #(
  .ADDR_W(ADDR_W), .DIV_W(DIV_W), .ADDR_CTL(ADDR_CTL),
  .ADDR_DIV_LO(ADDR_DIV_LO), .ADDR_SHARED(ADDR_SHARED)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .tx_en_o(tx_en_o),
  .parity_en_o(parity_en_o), .parity_odd_o(parity_odd_o),
  .sync_mode_o(sync_mode_o), .stop2_o(stop2_o), .char_bits_o(char_bits_o),
  .clk_pol_o(clk_pol_o), .divisor_o(divisor_o)
);

// File: tb/uart_cfg_regs_tb.sv
module uart_cfg_regs_tb;
  localparam int ADDR_W = 4;
  localparam int DIV_W  = 12;
  localparam logic [3:0] A_CTL = 4'd1, A_LO = 4'd2, A_SH = 4'd7;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic             we_i = 1'b0;
  logic [7:0]       wdata_i = '0;
  logic [7:0]       rdata_o;
  logic             tx_en_o, rx_en_o, sync_mode_o, parity_en_o, parity_odd_o;
  logic             stop2_o, clk_pol_o;
  logic [3:0]       char_bits_o;
  logic [DIV_W-1:0] divisor_o;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 0;

  // reference model state
  logic [6:0]  m_fmt;
  logic [2:0]  m_ctl;
  logic [3:0]  m_hi;
  logic [11:0] m_div;

  always #10 clk_i = ~clk_i;

  uart_cfg_regs u_dut (
    .clk_i, .rst_ni, .addr_i, .we_i, .wdata_i, .rdata_o, .tx_en_o, .rx_en_o,
    .sync_mode_o, .parity_en_o, .parity_odd_o, .stop2_o, .char_bits_o,
    .clk_pol_o, .divisor_o
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_bits(input logic s2, input logic [1:0] s);
    int code = {s2, s};
    if (code == 0) return 5;
    if (code == 1) return 6;
    if (code == 2) return 7;
    if (code == 7) return 9;
    return 8;
  endfunction

  function automatic logic [7:0] m_read(input logic [3:0] a);
    if (a == A_SH)  return {1'b1, m_fmt};
    if (a == A_CTL) return {5'd0, m_ctl};
    if (a == A_LO)  return m_div[7:0];
    return 8'h00;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_fmt = 7'h06; m_ctl = 3'b000; m_hi = 4'h0; m_div = 12'h000;
    end else if (we_i) begin
      if (addr_i == A_SH && wdata_i[7])  m_fmt = wdata_i[6:0];
      if (addr_i == A_SH && !wdata_i[7]) m_hi  = wdata_i[3:0];
      if (addr_i == A_CTL)               m_ctl = wdata_i[2:0];
      if (addr_i == A_LO)                m_div = {m_hi, wdata_i};
    end
  end

  // every-cycle comparison of the decoded outputs
  always @(negedge clk_i) begin
    if (!done) begin
      chk("R6 divisor", divisor_o, m_div);
      chk("R7 tx_en", tx_en_o, m_ctl[1]);
      chk("R7 rx_en", rx_en_o, m_ctl[2]);
      chk("R10 sync_mode", sync_mode_o, m_fmt[6]);
      chk("R10 stop2", stop2_o, m_fmt[3]);
      chk("R10 clk_pol", clk_pol_o, m_fmt[0]);
      chk("R9 parity_en", parity_en_o, m_fmt[5]);
      chk("R9 parity_odd", parity_odd_o, m_fmt[5] & m_fmt[4]);
      chk("R8 char_bits", char_bits_o, exp_bits(m_ctl[0], m_fmt[2:1]));
    end
  end

  // drive one cycle; read data is checked against pre-write state (R12)
  task automatic op(input logic [3:0] a, input logic w, input logic [7:0] d, input string tag);
    @(negedge clk_i);
    addr_i = a; we_i = w; wdata_i = d;
    #1;
    chk(w ? {tag, " R12 read-during-write"} : tag, rdata_o, m_read(a));
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1: reset contents
    op(A_SH, 0, 8'h00, "R1 shared reset");
    chk("R1 shared reset value", rdata_o, 8'h86);
    op(A_CTL, 0, 8'h00, "R1 ctl reset");
    op(A_LO, 0, 8'h00, "R1 div_lo reset");
    op(4'd0, 0, 8'h00, "R11 unmapped read");
    // R2: format write, R4 readback
    op(A_SH, 1, 8'hA5, "R2 fmt write");
    op(A_SH, 0, 8'h00, "R4 fmt readback");
    chk("R4 fmt value", rdata_o, 8'hA5);
    // R3: stage high nibble, format untouched, divisor held
    op(A_SH, 1, 8'h3F, "R3 hi stage");
    op(A_SH, 0, 8'h00, "R3 fmt kept");
    chk("R3 fmt unchanged", rdata_o, 8'hA5);
    // R5: commit
    op(A_LO, 1, 8'h34, "R5 lo write");
    op(A_LO, 0, 8'h00, "R5 lo readback");
    chk("R5 divisor", divisor_o, 12'hF34);
    // R2: format write keeps staged nibble
    op(A_SH, 1, 8'hFF, "R2 fmt all ones");
    op(A_LO, 1, 8'h00, "R2 commit after fmt");
    op(A_LO, 0, 8'h00, "R2 readback");
    chk("R2 staged nibble kept", divisor_o, 12'hF00);
    op(A_SH, 0, 8'h00, "R4 msb kept");
    chk("R4 read all ones", rdata_o, 8'hFF);
    // R7: control register
    op(A_CTL, 1, 8'hFF, "R7 ctl write");
    op(A_CTL, 0, 8'h00, "R7 ctl readback");
    chk("R7 ctl upper zero", rdata_o, 8'h07);
    // R8 / R9: sweep size and parity codes
    for (int code = 0; code < 8; code++) begin
      op(A_CTL, 1, {7'd0, code[2]} | 8'h06, "R8 size2");
      op(A_SH, 1, {1'b1, 1'b0, code[1:0], 1'b0, code[1:0], 1'b1}, "R8/R9 fmt sweep");
      op(A_SH, 0, 8'h00, "R8 readback");
    end
    op(A_SH, 1, 8'h90, "R9 reserved parity");
    op(A_SH, 0, 8'h00, "R9 readback");
    // R11: writes to unmapped addresses
    op(4'd0, 1, 8'hFF, "R11 unmapped write 0");
    op(4'd3, 1, 8'h81, "R11 unmapped write 3");
    op(4'd8, 1, 8'h00, "R11 unmapped write 8");
    op(4'd15, 1, 8'hFF, "R11 unmapped write 15");
    op(A_SH, 0, 8'h00, "R11 fmt intact");
    op(A_CTL, 0, 8'h00, "R11 ctl intact");
    op(A_LO, 0, 8'h00, "R11 lo intact");
    // R6: high stage without commit leaves divisor
    op(A_SH, 1, 8'h05, "R6 hi stage");
    op(A_SH, 0, 8'h00, "R6 no commit");
    op(A_SH, 0, 8'h00, "R6 no commit 2");
    op(A_LO, 1, 8'hC3, "R5 second commit");
    op(A_LO, 0, 8'h00, "R5 second readback");
    chk("R5 divisor second", divisor_o, 12'h5C3);
    @(negedge clk_i);
    we_i = 1'b0;
    @(negedge clk_i);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc == 20000 && !done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule